// File: doc/BRIEF.md
# Byte-wide non-volatile array controller with armed, timed programming

This block sits on a CPU's data bus and manages a 1024-byte on-chip non-volatile array through four byte-wide registers: a control register, a data register and a low/high address pair. Software reads a byte by setting the read bit in the control register. The block copies the selected byte into the data register and holds the CPU stalled for four cycles. Programming is guarded. The arm bit has to be set first, and the program bit must then be written within the next four cycles. A program that is accepted stalls the CPU for two cycles and keeps the program bit set as a busy flag for a parameterised number of cycles. Only at the end of that time is the byte committed to the array.

Three program modes exist. Erase-then-write stores the data byte exactly. Erase-only stores 0xFF. Write-only can only clear bits: it stores the old byte ANDed with the data. The fourth mode code is reserved and does nothing. After a program finishes, a level interrupt request reports that the block is ready, provided the interrupt-enable bit and the global interrupt enable are both set. The array is modelled as a register file that resets to the erased value 0xFF.

The sequencer has four states. `ST_IDLE` accepts requests. `ST_RD_HOLD` stalls the CPU after a read. `ST_PG_HOLD` stalls the CPU after a program start while the program timer is already running. `ST_PG_RUN` covers the rest of the program time. The transitions are:
- `ST_IDLE` to `ST_PG_HOLD` on an accepted program request. This takes priority over a read in the same write.
- `ST_IDLE` to `ST_RD_HOLD` on a read request.
- `ST_RD_HOLD` to `ST_IDLE` when the stall count runs out.
- `ST_PG_HOLD` to `ST_PG_RUN` when the stall count runs out.
- `ST_PG_RUN` to `ST_IDLE` when the program timer reaches zero. The commit happens on this transition.

Top module: `nvm_byte_ctrl`

## Requirements
- R1: Bus writes and reads decode four addresses. 0x3F is the control register, 0x40 the data register, 0x41 the address low byte and 0x42 the address high byte. The array address is {high[1:0], low}, so high 0x02 with low 0x50 selects byte 0x250. The high register reads back with bits 7:2 as zero.
- R2: After reset the control register reads 0x00, the stall and interrupt outputs are low, and every array byte reads 0xFF.
- R3: Control bits: bit0 read, bit1 program (reads back as busy), bit2 arm, bit3 interrupt enable, bits 5:4 mode. Bit0 always reads back 0. Writing control with bit0 set while idle loads the addressed byte into the data register and drives the stall output high for exactly 4 cycles.
- R4: After a control write with bit2 set, the arm bit reads 1 for 4 cycles and then clears by itself. A program request on any of the 4 clock edges after the arm write is accepted. A request on any later edge is not.
- R5: A program request (control write with bit1 set) while the arm bit is clear does nothing: busy stays 0 and the array is unchanged.
- R6: An accepted program request stalls the CPU for exactly 2 cycles. Busy then reads 1 for exactly PROG_CYCLES cycles, with a default of 2500, and the array byte is updated when busy clears.
- R7: Mode 00 (bits 5:4 of the starting control write) stores the data byte exactly.
- R8: Mode 10 stores the old byte ANDed with the data byte. Old 0x0F with data 0x55 gives 0x05.
- R9: Mode 01 stores 0xFF whatever the data byte is.
- R10: Mode 11 is reserved. A request with it does not start a program: busy stays 0 and the array is unchanged.
- R11: A program request while busy is ignored. The address and data captured at the first start are the ones committed, even if the data and address registers are rewritten meanwhile.
- R12: A read request while busy is ignored, and the data register keeps its value.
- R13: The interrupt output is high exactly when the interrupt-enable bit is set, the global interrupt input is high and no program is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the register at bus_addr (combinational) |
| cpu_stall | output | 1 | Holds the CPU after a read or a program start |
| gie | input | 1 | Global interrupt enable from the CPU |
| irq | output | 1 | Ready interrupt request (level) |

## Verification
The bench probes the arm window at both of its edges: a program on the fourth cycle after arming must start, and one on the fifth must not. A window that is off by one either rejects legal sequences or lets a late write through. It counts busy cycles exactly and rewrites the address and data registers during a program. A design that committed from the live registers would write the wrong byte to the wrong location, and one that did not block a second request would write a second location. Write-only and erase-only are run on a byte with known contents, so a design that confused the modes or ignored the old value would produce 0x55 or 0x33 instead of 0x05 or 0xFF. Random programs in all four mode codes over a small address pool are checked against a bench model of the array.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_HOLD = 2'd1,
        ST_PG_HOLD = 2'd2,
        ST_PG_RUN  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_ERASE_WRITE = 2'b00,
        MODE_ERASE_ONLY  = 2'b01,
        MODE_WRITE_ONLY  = 2'b10,
        MODE_RESERVED    = 2'b11
    } pgm_mode_t;

    localparam int CB_READ = 0;
    localparam int CB_PROG = 1;
    localparam int CB_ARM  = 2;
    localparam int CB_IE   = 3;
    localparam int CB_MLO  = 4;
    localparam int CB_MHI  = 5;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
    parameter int WINDOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_set,
    input  logic arm_clr,
    output logic armed
);
    localparam int CW = $clog2(WINDOW + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm_clr) begin
            cnt_q <= '0;
        end else if (arm_set) begin
            cnt_q <= CW'(WINDOW);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign armed = (cnt_q != '0);

endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_pkg::*;
#(
    parameter int PROG_CYCLES = 2500,
    parameter int RD_STALL    = 4,
    parameter int PG_STALL    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic pg_req,
    output logic idle,
    output logic busy,
    output logic stall,
    output logic commit
);
    localparam int PW   = $clog2(PROG_CYCLES + 1);
    localparam int SMAX = (RD_STALL > PG_STALL) ? RD_STALL : PG_STALL;
    localparam int SW   = $clog2(SMAX + 1);

    seq_state_t    state_q, state_d;
    logic [PW-1:0] pcnt_q;
    logic [SW-1:0] scnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pg_req)      state_d = ST_PG_HOLD;
                else if (rd_req) state_d = ST_RD_HOLD;
            end
            ST_RD_HOLD: if (scnt_q == '0) state_d = ST_IDLE;
            ST_PG_HOLD: if (scnt_q == '0) state_d = ST_PG_RUN;
            ST_PG_RUN:  if (pcnt_q == '0) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            scnt_q <= '0;
        end else if (state_q == ST_IDLE) begin
            if (pg_req) begin
                pcnt_q <= PW'(PROG_CYCLES - 1);
                scnt_q <= SW'(PG_STALL - 1);
            end else if (rd_req) begin
                scnt_q <= SW'(RD_STALL - 1);
            end
        end else begin
            if (scnt_q != '0) scnt_q <= scnt_q - 1'b1;
            if (state_q != ST_RD_HOLD && pcnt_q != '0) pcnt_q <= pcnt_q - 1'b1;
        end
    end

    always_comb begin
        idle   = 1'b0;
        busy   = 1'b0;
        stall  = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            ST_IDLE:    idle = 1'b1;
            ST_RD_HOLD: stall = 1'b1;
            ST_PG_HOLD: begin
                stall = 1'b1;
                busy  = 1'b1;
            end
            ST_PG_RUN: begin
                busy   = 1'b1;
                commit = (pcnt_q == '0);
            end
            default: idle = 1'b1;
        endcase
    end

endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array
    import nvm_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic          pg_start,
    input  logic [AW-1:0] pg_addr,
    input  logic [7:0]    pg_data,
    input  logic [1:0]    pg_mode,
    input  logic          commit,
    output logic [AW-1:0] lat_addr
);
    logic [7:0]    mem_q [DEPTH];
    logic [AW-1:0] lat_addr_q;
    logic [7:0]    lat_data_q;
    pgm_mode_t     lat_mode_q;
    logic [7:0]    new_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr_q <= '0;
            lat_data_q <= '0;
            lat_mode_q <= MODE_ERASE_WRITE;
        end else if (pg_start) begin
            lat_addr_q <= pg_addr;
            lat_data_q <= pg_data;
            lat_mode_q <= pgm_mode_t'(pg_mode);
        end
    end

    always_comb begin
        unique case (lat_mode_q)
            MODE_ERASE_WRITE: new_byte = lat_data_q;
            MODE_ERASE_ONLY:  new_byte = ERASED_BYTE;
            MODE_WRITE_ONLY:  new_byte = mem_q[lat_addr_q] & lat_data_q;
            default:          new_byte = mem_q[lat_addr_q];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED_BYTE;
        end else if (commit) begin
            mem_q[lat_addr_q] <= new_byte;
        end
    end

    assign rd_data  = mem_q[rd_addr];
    assign lat_addr = lat_addr_q;

endmodule

// File: rtl/nvm_byte_ctrl.sv
module nvm_byte_ctrl
    import nvm_pkg::*;
#(
    parameter int         DEPTH       = 1024,
    parameter int         PROG_CYCLES = 2500,
    parameter int         ARM_WINDOW  = 4,
    parameter int         RD_STALL    = 4,
    parameter int         PG_STALL    = 2,
    parameter logic [7:0] REG_BASE    = 8'h3F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       cpu_stall,
    input  logic       gie,
    output logic       irq
);
    localparam int         AW       = $clog2(DEPTH);
    localparam int         HW       = AW - 8;
    localparam logic [7:0] A_CTRL   = REG_BASE;
    localparam logic [7:0] A_DATA   = REG_BASE + 8'd1;
    localparam logic [7:0] A_ADDR_L = REG_BASE + 8'd2;
    localparam logic [7:0] A_ADDR_H = REG_BASE + 8'd3;

    logic [7:0]    data_q;
    logic [7:0]    alo_q;
    logic [HW-1:0] ahi_q;
    logic          ie_q;
    logic [1:0]    mode_q;

    logic sel_ctrl, sel_data, sel_alo, sel_ahi;
    logic armed, idle, busy, commit;
    logic pg_req, rd_req, rd_load;
    logic [AW-1:0] cur_addr, lat_addr;
    logic [7:0]    arr_rdata;

    assign sel_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign sel_data = bus_wr && (bus_addr == A_DATA);
    assign sel_alo  = bus_wr && (bus_addr == A_ADDR_L);
    assign sel_ahi  = bus_wr && (bus_addr == A_ADDR_H);
    assign cur_addr = {ahi_q, alo_q};

    assign pg_req  = sel_ctrl && bus_wdata[CB_PROG] && armed && idle
                     && (bus_wdata[CB_MHI:CB_MLO] != MODE_RESERVED);
    assign rd_req  = sel_ctrl && bus_wdata[CB_READ] && idle;
    assign rd_load = rd_req && !pg_req;

    nvm_arm_window #(.WINDOW(ARM_WINDOW)) u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_set (sel_ctrl && bus_wdata[CB_ARM] && !pg_req),
        .arm_clr (pg_req),
        .armed   (armed)
    );

    nvm_seq #(
        .PROG_CYCLES (PROG_CYCLES),
        .RD_STALL    (RD_STALL),
        .PG_STALL    (PG_STALL)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_req (rd_req),
        .pg_req (pg_req),
        .idle   (idle),
        .busy   (busy),
        .stall  (cpu_stall),
        .commit (commit)
    );

    nvm_cell_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (cur_addr),
        .rd_data  (arr_rdata),
        .pg_start (pg_req),
        .pg_addr  (cur_addr),
        .pg_data  (data_q),
        .pg_mode  (bus_wdata[CB_MHI:CB_MLO]),
        .commit   (commit),
        .lat_addr (lat_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            alo_q  <= '0;
            ahi_q  <= '0;
            ie_q   <= 1'b0;
            mode_q <= '0;
        end else begin
            if (rd_load)       data_q <= arr_rdata;
            else if (sel_data) data_q <= bus_wdata;
            if (sel_alo) alo_q <= bus_wdata;
            if (sel_ahi) ahi_q <= bus_wdata[HW-1:0];
            if (sel_ctrl) ie_q <= bus_wdata[CB_IE];
            if (sel_ctrl && !busy) mode_q <= bus_wdata[CB_MHI:CB_MLO];
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:   bus_rdata = {2'b00, mode_q, ie_q, armed, busy, 1'b0};
            A_DATA:   bus_rdata = data_q;
            A_ADDR_L: bus_rdata = alo_q;
            A_ADDR_H: bus_rdata = {{(8-HW){1'b0}}, ahi_q};
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign irq = ie_q && gie && !busy;

endmodule

// File: rtl/nvm_byte_ctrl_chk.sv
module nvm_byte_ctrl_chk #(
    parameter int PROG_CYCLES = 2500,
    parameter int ARM_WINDOW  = 4,
    parameter int AW          = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_wr,
    input logic          arm_wr,
    input logic          cpu_stall,
    input logic          irq,
    input logic          busy,
    input logic          armed,
    input logic [AW-1:0] lat_addr
);
    int busy_len;
    int arm_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len <= 0;
            arm_age  <= ARM_WINDOW;
        end else begin
            busy_len <= busy ? busy_len + 1 : 0;
            if (arm_wr)                  arm_age <= 0;
            else if (arm_age < ARM_WINDOW) arm_age <= arm_age + 1;
        end
    end

    // R3: a stall only starts after a control write
    a_r3_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> $past(ctrl_wr));

    // R4: the arm bit lasts no longer than the window after its write
    a_r4_arm_window: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (arm_age < ARM_WINDOW));

    // R5: a program only starts while armed
    a_r5_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed));

    // R6: busy lasts exactly the program time
    a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == PROG_CYCLES));

    // R11: the captured address does not move during a program
    a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lat_addr));

    // R13: no ready request while a program is running
    a_r13_no_irq_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq);

endmodule

bind nvm_byte_ctrl nvm_byte_ctrl_chk #(
    .PROG_CYCLES (PROG_CYCLES),
    .ARM_WINDOW  (ARM_WINDOW),
    .AW          (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (sel_ctrl),
    .arm_wr    (sel_ctrl && bus_wdata[2]),
    .cpu_stall (cpu_stall),
    .irq       (irq),
    .busy      (busy),
    .armed     (armed),
    .lat_addr  (lat_addr)
);

// File: tb/nvm_byte_ctrl_bench.sv
module nvm_byte_ctrl_bench;
    localparam int PC = 2500;
    localparam logic [7:0] A_CTRL = 8'h3F;
    localparam logic [7:0] A_DATA = 8'h40;
    localparam logic [7:0] A_LO   = 8'h41;
    localparam logic [7:0] A_HI   = 8'h42;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cpu_stall;
    logic       gie = 1'b0;
    logic       irq;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    logic [7:0] model [1024];

    always #2.5 clk = ~clk;

    nvm_byte_ctrl #(.PROG_CYCLES(PC)) u_nvm_byte_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_stall (cpu_stall),
        .gie       (gie),
        .irq       (irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] expect_byte(input logic [7:0] old, input logic [7:0] d,
                                               input logic [1:0] m);
        case (m)
            2'b00:   return d;
            2'b01:   return 8'hFF;
            2'b10:   return old & d;
            default: return old;
        endcase
    endfunction

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R7";
            2'b01:   return "R9";
            2'b10:   return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic set_addr(input logic [9:0] a);
        wr(A_LO, a[7:0]);
        wr(A_HI, {6'b0, a[9:8]});
    endtask

    task automatic nvm_get(input logic [9:0] a, output logic [7:0] v);
        set_addr(a);
        wr(A_CTRL, 8'h01);
        idle(5);
        rd(A_DATA, v);
    endtask

    task automatic pgm(input logic [9:0] a, input logic [7:0] d, input logic [1:0] m, input bit ie);
        wr(A_DATA, d);
        set_addr(a);
        wr(A_CTRL, {2'b00, m, ie, 3'b100});
        wr(A_CTRL, {2'b00, m, ie, 3'b010});
    endtask

    task automatic commit_model(input logic [9:0] a, input logic [7:0] d, input logic [1:0] m);
        model[a] = expect_byte(model[a], d, m);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) model[i] = 8'hFF;

        idle(3);
        rst_n = 1'b1;
        gie   = 1'b1;
        idle(1);

        // R2 reset state
        rd(A_CTRL, v);
        check(v == 8'h00, "R2 ctrl after reset", v, 0);
        check(!cpu_stall && !irq, "R2 stall/irq after reset", {cpu_stall, irq}, 0);
        nvm_get(10'h000, v);
        check(v == 8'hFF, "R2 erased byte", v, 8'hFF);

        // R3 read stall length
        set_addr(10'h123);
        wr(A_CTRL, 8'h01);
        n = 0;
        while (cpu_stall && n < 20) begin n++; @(negedge clk); end
        check(n == 4, "R3 read stall cycles", n, 4);
        rd(A_CTRL, v);
        check(v[0] == 1'b0, "R3 read bit reads 0", v[0], 0);

        // R1 address formation and register readback
        pgm(10'h250, 8'h42, 2'b00, 1'b0);
        idle(PC + 4);
        commit_model(10'h250, 8'h42, 2'b00);
        wr(A_LO, 8'h50);
        wr(A_HI, 8'h02);
        rd(A_LO, v);
        check(v == 8'h50, "R1 low readback", v, 8'h50);
        wr(A_CTRL, 8'h01);
        idle(5);
        rd(A_DATA, v);
        check(v == 8'h42, "R1 byte 0x250", v, 8'h42);
        wr(A_HI, 8'hFF);
        rd(A_HI, v);
        check(v == 8'h03, "R1 high upper bits zero", v, 8'h03);

        // R5 program without arm
        wr(A_DATA, 8'h11);
        set_addr(10'h020);
        wr(A_CTRL, 8'h02);
        rd(A_CTRL, v);
        check(v[1] == 1'b0, "R5 no busy without arm", v[1], 0);
        idle(PC + 4);
        nvm_get(10'h020, v);
        check(v == 8'hFF, "R5 array unchanged", v, 8'hFF);

        // R4 arm window: late start rejected
        wr(A_DATA, 8'h22);
        set_addr(10'h021);
        wr(A_CTRL, 8'h04);
        idle(3);
        rd(A_CTRL, v);
        check(v[2] == 1'b1, "R4 armed at cycle 4", v[2], 1);
        idle(1);
        rd(A_CTRL, v);
        check(v[2] == 1'b0, "R4 arm cleared at cycle 5", v[2], 0);
        wr(A_CTRL, 8'h02);
        rd(A_CTRL, v);
        check(v[1] == 1'b0, "R4 start on edge 5 rejected", v[1], 0);

        // R4 boundary accept, R6 timing
        wr(A_CTRL, 8'h04);
        idle(3);
        wr(A_CTRL, 8'h02);
        n = 0;
        while (cpu_stall && n < 20) begin n++; @(negedge clk); end
        check(n == 2, "R6 program stall cycles", n, 2);
        rd(A_CTRL, v);
        check(v[1] == 1'b1, "R4 start on edge 4 accepted", v[1], 1);
        idle(997);
        rd(A_CTRL, v);
        check(v[1] == 1'b1, "R6 busy after 1000 cycles", v[1], 1);
        idle(PC - 1000);
        rd(A_CTRL, v);
        check(v[1] == 1'b1, "R6 busy in last cycle", v[1], 1);
        idle(1);
        rd(A_CTRL, v);
        check(v[1] == 1'b0, "R6 busy clears after PROG_CYCLES", v[1], 0);
        commit_model(10'h021, 8'h22, 2'b00);
        nvm_get(10'h021, v);
        check(v == 8'h22, "R7 exact store", v, 8'h22);

        // R11 overlap ignored, latched copy committed; R12 read while busy
        pgm(10'd15, 8'h55, 2'b00, 1'b0);
        idle(10);
        pgm(10'd16, 8'h66, 2'b00, 1'b0);
        wr(A_CTRL, 8'h01);
        idle(5);
        rd(A_DATA, v);
        check(v == 8'h66, "R12 read while busy ignored", v, 8'h66);
        idle(PC);
        commit_model(10'd15, 8'h55, 2'b00);
        nvm_get(10'd15, v);
        check(v == 8'h55, "R11 first write committed", v, 8'h55);
        nvm_get(10'd16, v);
        check(v == 8'hFF, "R11 second write dropped", v, 8'hFF);

        // R8, R9, R10 modes on a known byte
        pgm(10'd9, 8'h0F, 2'b00, 1'b0);
        idle(PC + 4);
        pgm(10'd9, 8'h55, 2'b10, 1'b0);
        idle(PC + 4);
        nvm_get(10'd9, v);
        check(v == 8'h05, "R8 write-only clears bits", v, 8'h05);
        pgm(10'd9, 8'h33, 2'b11, 1'b0);
        rd(A_CTRL, v);
        check(v[1] == 1'b0, "R10 reserved mode no busy", v[1], 0);
        idle(PC + 4);
        nvm_get(10'd9, v);
        check(v == 8'h05, "R10 reserved mode unchanged", v, 8'h05);
        pgm(10'd9, 8'h33, 2'b01, 1'b0);
        idle(PC + 4);
        nvm_get(10'd9, v);
        check(v == 8'hFF, "R9 erase-only", v, 8'hFF);
        model[9] = 8'hFF;

        // R13 interrupt level
        pgm(10'd30, 8'hA5, 2'b00, 1'b1);
        idle(5);
        check(irq == 1'b0, "R13 irq low while busy", irq, 0);
        idle(PC);
        check(irq == 1'b1, "R13 irq high when ready", irq, 1);
        commit_model(10'd30, 8'hA5, 2'b00);
        gie = 1'b0;
        #1;
        check(irq == 1'b0, "R13 irq gated by gie", irq, 0);
        gie = 1'b1;
        wr(A_CTRL, 8'h00);
        check(irq == 1'b0, "R13 irq off with enable clear", irq, 0);

        // random programs over a small pool, all mode codes
        for (int k = 0; k < 14; k++) begin
            logic [9:0] a;
            logic [7:0] d;
            logic [1:0] m;
            a = 10'h300 + 10'($urandom_range(0, 5));
            d = 8'($urandom);
            m = 2'($urandom_range(0, 3));
            pgm(a, d, m, 1'b0);
            idle(PC + 4);
            commit_model(a, d, m);
            nvm_get(a, v);
            check(v == model[a], {mode_tag(m), " random program"}, v, model[a]);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule